// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers 64 peripheral interrupt lines and 8 local interrupt lines. All of them are level-sensitive and are used as they arrive, with no latching. For each line a mask bit decides whether that line takes part in the shared IRQ output. Software changes the masks only through two kinds of register. A set-mask register turns on every line whose data bit is 1. A clear-mask register turns off every line whose data bit is 1. Lines whose data bit is 0 keep their mask bit either way.

A separate FIQ path follows one line chosen by software. It uses that line's raw level and ignores the masks.

Software reads the masked pending state in three places:
- two 32-bit halves for the peripheral lines;
- one summary word that packs the local lines, a non-zero flag for each peripheral half, and copies of eleven fixed peripheral lines.

The register port carries a valid strobe, a write flag, a byte address and 32-bit write data. The block accepts every request in the cycle it is presented, so the port has no back-pressure and no ready signal. A read returns its data one cycle later, marked by a response strobe. Both interrupt outputs are registered.

Top module: `dual_bank_intc`

## Requirements
- R1: Reset clears every mask bit, the FIQ enable and the FIQ select field, and drives `irq_o`, `fiq_o` and `bus_rsp_o` low.
- R2: A write to a set-mask register turns on each mask bit whose data bit is 1. Offset 0x10 covers peripheral lines 0–31, offset 0x14 covers lines 32–63 and offset 0x18 covers local lines 0–7. A read of these offsets returns the mask, with the local mask zero-extended.
- R3: A write to a clear-mask register turns off each mask bit whose data bit is 1. Offset 0x1C covers peripheral lines 0–31, 0x20 covers lines 32–63 and 0x24 covers the local lines. In both R2 and R3, mask bits whose data bit is 0 keep their value.
- R4: A read of 0x1C, 0x20 or 0x24 returns the bitwise inverse of the matching 32-bit mask word. For the local lines this is the inverse of the zero-extended mask, so bits 31:8 read as 1.
- R5: Offset 0x04 reads the level of lines 0–31 ANDed with their mask bits. Offset 0x08 does the same for lines 32–63.
- R6: In the summary word at offset 0x00, bits 7:0 are the masked local lines. Bit 8 is 1 when any masked line among 0–31 is high. Bit 9 is 1 when any masked line among 32–63 is high.
- R7: Summary bits 20:10 carry the masked state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, with line 7 at bit 10. Bits 31:21 read 0.
- R8: A write to 0x0C loads the FIQ select from data bits 6:0 and the FIQ enable from data bit 7. A read of 0x0C returns these fields in the same positions, with the upper bits 0.
- R9: While FIQ is enabled and the select is below 64, `fiq_o` follows the raw level of that peripheral line, whatever the masks hold.
- R10: A select of 64 to 71 routes local line (select − 64) to `fiq_o`. A select of 72 or above drives `fiq_o` low.
- R11: While FIQ is disabled, `fiq_o` is 0.
- R12: `irq_o` is 1 exactly when some line that is both masked-on and high is present.
- R13: A read of an unmapped offset returns 0. A write to an unmapped offset or to a read-only offset (0x00, 0x04, 0x08) changes nothing.
- R14: A read is answered on the next cycle with `bus_rsp_o` high and the data on `bus_rdata_o`. Writes raise no response. Each output follows its inputs and the register state one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_lvl_i | input | 64 | Peripheral interrupt levels |
| loc_lvl_i | input | 8 | Local interrupt levels |
| bus_valid_i | input | 1 | Register request strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rsp_o | output | 1 | Read data valid, one cycle after a read |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Registered OR of all masked, high lines |
| fiq_o | output | 1 | Registered level of the selected FIQ source |

## Verification
The bound checker watches several rules on every cycle:
- the set-mask and clear-mask effect on the low peripheral bank;
- `irq_o` against the masked levels of the cycle before;
- the FIQ output while FIQ is disabled, and while a peripheral source is selected;
- the zero reply to unmapped reads;
- the response strobe timing.

Only the bench scenarios can show the rest: the packing of the summary word, the inverse read-back of the clear-mask offsets, FIQ routing to local sources and to out-of-range selects, and the fact that writes to read-only offsets leave the state unchanged.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int FIQ_SEL_W   = 7;
  localparam int FIQ_EN_BIT  = 7;
  localparam int NUM_MIRROR  = 11;

  typedef enum logic [3:0] {
    REG_SUMMARY,
    REG_PEND_LO,
    REG_PEND_HI,
    REG_FIQ_CTL,
    REG_SET_LO,
    REG_SET_HI,
    REG_SET_LOC,
    REG_CLR_LO,
    REG_CLR_HI,
    REG_CLR_LOC,
    REG_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    case (a)
      32'h00:  return REG_SUMMARY;
      32'h04:  return REG_PEND_LO;
      32'h08:  return REG_PEND_HI;
      32'h0C:  return REG_FIQ_CTL;
      32'h10:  return REG_SET_LO;
      32'h14:  return REG_SET_HI;
      32'h18:  return REG_SET_LOC;
      32'h1C:  return REG_CLR_LO;
      32'h20:  return REG_CLR_HI;
      32'h24:  return REG_CLR_LOC;
      default: return REG_NONE;
    endcase
  endfunction

  // Peripheral line mirrored into summary slot k (slot order is fixed).
  function automatic int mirror_line(input int k);
    case (k)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      4:       return 19;
      5:       return 53;
      6:       return 54;
      7:       return 55;
      8:       return 56;
      9:       return 57;
      default: return 62;
    endcase
  endfunction

endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);

  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_we) mask_q <= mask_q | wdata_i;
    else if (clr_we) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/intc_fiq_route.sv
module intc_fiq_route
  import intc_pkg::*;
#(
  parameter int NUM_PER = 64,
  parameter int NUM_LOC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_wdata_i,
  input  logic [NUM_PER-1:0]   per_lvl_i,
  input  logic [NUM_LOC-1:0]   loc_lvl_i,
  output logic                 fiq_en_o,
  output logic [FIQ_SEL_W-1:0] fiq_sel_o,
  output logic                 fiq_hit_o
);

  localparam int SRC_N = NUM_PER + NUM_LOC;

  logic                 en_q;
  logic [FIQ_SEL_W-1:0] sel_q;
  logic [SRC_N-1:0]     src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (ctl_we) begin
      en_q  <= ctl_wdata_i[FIQ_EN_BIT];
      sel_q <= ctl_wdata_i[FIQ_SEL_W-1:0];
    end
  end

  // Local lines sit directly above the peripheral lines.
  assign src = {loc_lvl_i, per_lvl_i};

  always_comb begin
    fiq_hit_o = 1'b0;
    if (en_q && (int'(sel_q) < SRC_N))
      fiq_hit_o = src[sel_q];
  end

  assign fiq_en_o  = en_q;
  assign fiq_sel_o = sel_q;

endmodule

// File: rtl/intc_status.sv
module intc_status
  import intc_pkg::*;
#(
  parameter int NUM_PER = 64,
  parameter int NUM_LOC = 8,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_PER-1:0]   per_lvl_i,
  input  logic [NUM_LOC-1:0]   loc_lvl_i,
  input  logic [NUM_PER-1:0]   en_per_i,
  input  logic [NUM_LOC-1:0]   en_loc_i,
  input  logic                 fiq_en_i,
  input  logic [FIQ_SEL_W-1:0] fiq_sel_i,
  input  reg_sel_e             sel_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 any_pend_o
);

  localparam int SUM_W = NUM_LOC + 2 + NUM_MIRROR;

  logic [NUM_PER-1:0] pend_per;
  logic [NUM_LOC-1:0] pend_loc;
  logic [SUM_W-1:0]   summary;
  logic [DATA_W-1:0]  loc_word;
  logic [DATA_W-1:0]  fiq_word;

  assign pend_per = per_lvl_i & en_per_i;
  assign pend_loc = loc_lvl_i & en_loc_i;

  assign summary[NUM_LOC-1:0] = pend_loc;
  assign summary[NUM_LOC]     = |pend_per[DATA_W-1:0];
  assign summary[NUM_LOC+1]   = |pend_per[NUM_PER-1:DATA_W];

  for (genvar k = 0; k < NUM_MIRROR; k++) begin : g_mirror
    assign summary[NUM_LOC+2+k] = pend_per[mirror_line(k)];
  end

  assign loc_word = {{(DATA_W-NUM_LOC){1'b0}}, en_loc_i};
  assign fiq_word = {{(DATA_W-FIQ_SEL_W-1){1'b0}}, fiq_en_i, fiq_sel_i};

  always_comb begin
    case (sel_i)
      REG_SUMMARY: rdata_o = {{(DATA_W-SUM_W){1'b0}}, summary};
      REG_PEND_LO: rdata_o = pend_per[DATA_W-1:0];
      REG_PEND_HI: rdata_o = pend_per[NUM_PER-1:DATA_W];
      REG_FIQ_CTL: rdata_o = fiq_word;
      REG_SET_LO:  rdata_o = en_per_i[DATA_W-1:0];
      REG_SET_HI:  rdata_o = en_per_i[NUM_PER-1:DATA_W];
      REG_SET_LOC: rdata_o = loc_word;
      REG_CLR_LO:  rdata_o = ~en_per_i[DATA_W-1:0];
      REG_CLR_HI:  rdata_o = ~en_per_i[NUM_PER-1:DATA_W];
      REG_CLR_LOC: rdata_o = ~loc_word;
      default:     rdata_o = '0;
    endcase
  end

  assign any_pend_o = (|pend_per) | (|pend_loc);

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int NUM_PER = 64,
  parameter int NUM_LOC = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PER-1:0] per_lvl_i,
  input  logic [NUM_LOC-1:0] loc_lvl_i,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic               bus_rsp_o,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);

  localparam int NUM_BANKS = NUM_PER / DATA_W;

  reg_sel_e             sel;
  logic                 wr_acc;
  logic                 rd_acc;
  logic [NUM_PER-1:0]   en_per;
  logic [NUM_LOC-1:0]   en_loc;
  logic                 fiq_en;
  logic [FIQ_SEL_W-1:0] fiq_sel;
  logic                 fiq_hit;
  logic                 any_pend;
  logic [DATA_W-1:0]    rdata_c;

  logic                 irq_q;
  logic                 fiq_q;
  logic                 rsp_q;
  logic [DATA_W-1:0]    rdata_q;

  assign sel    = decode_addr(32'(bus_addr_i));
  assign wr_acc = bus_valid_i & bus_write_i;
  assign rd_acc = bus_valid_i & ~bus_write_i;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic set_we;
    logic clr_we;
    if (g == 0) begin : g_lo
      assign set_we = wr_acc && (sel == REG_SET_LO);
      assign clr_we = wr_acc && (sel == REG_CLR_LO);
    end else begin : g_hi
      assign set_we = wr_acc && (sel == REG_SET_HI);
      assign clr_we = wr_acc && (sel == REG_CLR_HI);
    end
    intc_mask_bank #(.W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (set_we),
      .clr_we  (clr_we),
      .wdata_i (bus_wdata_i),
      .mask_o  (en_per[g*DATA_W +: DATA_W])
    );
  end

  intc_mask_bank #(.W(NUM_LOC)) u_loc_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_we  (wr_acc && (sel == REG_SET_LOC)),
    .clr_we  (wr_acc && (sel == REG_CLR_LOC)),
    .wdata_i (bus_wdata_i[NUM_LOC-1:0]),
    .mask_o  (en_loc)
  );

  intc_fiq_route #(.NUM_PER(NUM_PER), .NUM_LOC(NUM_LOC)) u_fiq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (wr_acc && (sel == REG_FIQ_CTL)),
    .ctl_wdata_i (bus_wdata_i[7:0]),
    .per_lvl_i   (per_lvl_i),
    .loc_lvl_i   (loc_lvl_i),
    .fiq_en_o    (fiq_en),
    .fiq_sel_o   (fiq_sel),
    .fiq_hit_o   (fiq_hit)
  );

  intc_status #(.NUM_PER(NUM_PER), .NUM_LOC(NUM_LOC), .DATA_W(DATA_W)) u_status (
    .per_lvl_i  (per_lvl_i),
    .loc_lvl_i  (loc_lvl_i),
    .en_per_i   (en_per),
    .en_loc_i   (en_loc),
    .fiq_en_i   (fiq_en),
    .fiq_sel_i  (fiq_sel),
    .sel_i      (sel),
    .rdata_o    (rdata_c),
    .any_pend_o (any_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q   <= any_pend;
      fiq_q   <= fiq_hit;
      rsp_q   <= rd_acc;
      rdata_q <= rd_acc ? rdata_c : '0;
    end
  end

  assign irq_o       = irq_q;
  assign fiq_o       = fiq_q;
  assign bus_rsp_o   = rsp_q;
  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NUM_PER = 64,
  parameter int NUM_LOC = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PER-1:0]   per_lvl_i,
  input logic [NUM_LOC-1:0]   loc_lvl_i,
  input logic                 bus_valid_i,
  input logic                 bus_write_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [DATA_W-1:0]    bus_wdata_i,
  input logic                 bus_rsp_o,
  input logic [DATA_W-1:0]    bus_rdata_o,
  input logic                 irq_o,
  input logic                 fiq_o,
  input logic [NUM_PER-1:0]   en_per,
  input logic [NUM_LOC-1:0]   en_loc,
  input logic                 fiq_en,
  input logic [FIQ_SEL_W-1:0] fiq_sel
);

  logic     rd_req;
  logic     wr_req;
  reg_sel_e chk_sel;

  assign rd_req  = bus_valid_i & ~bus_write_i;
  assign wr_req  = bus_valid_i & bus_write_i;
  assign chk_sel = decode_addr(32'(bus_addr_i));

  assert_set_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && chk_sel == REG_SET_LO) |=>
      ((en_per[DATA_W-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  assert_clr_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && chk_sel == REG_CLR_LO) |=>
      ((en_per[DATA_W-1:0] & $past(bus_wdata_i)) == '0));

  assert_irq_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past((|(per_lvl_i & en_per)) | (|(loc_lvl_i & en_loc)))));

  assert_fiq_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_en |=> !fiq_o);

  assert_fiq_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_en && int'(fiq_sel) < NUM_PER) |=> (fiq_o == $past(per_lvl_i[fiq_sel[$clog2(NUM_PER)-1:0]])));

  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && chk_sel == REG_NONE) |=> (bus_rsp_o && bus_rdata_o == '0));

  assert_rsp_read_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rsp_o);

  assert_rsp_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rsp_o);

endmodule

bind dual_bank_intc intc_checker #(
  .NUM_PER(NUM_PER), .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .per_lvl_i   (per_lvl_i),
  .loc_lvl_i   (loc_lvl_i),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rsp_o   (bus_rsp_o),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .en_per      (en_per),
  .en_loc      (en_loc),
  .fiq_en      (fiq_en),
  .fiq_sel     (fiq_sel)
);

// File: tb/dual_bank_intc_bench.sv
`timescale 1ns/1ps
module dual_bank_intc_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] per = '0;
  logic [7:0]  loc = '0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp;
  logic [31:0] rdata;
  logic        irq;
  logic        fiq;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rst_n(rst_n), .per_lvl_i(per), .loc_lvl_i(loc),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rsp_o(rsp), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  // Reference state
  logic [63:0] m_en;
  logic [7:0]  m_enl;
  logic [6:0]  m_sel;
  logic        m_fen;

  localparam int MIR [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [63:0] p;
    logic [31:0] r;
    p = per & m_en;
    case (a)
      8'h00: begin
        r = '0;
        r[7:0] = loc & m_enl;
        r[8] = |p[31:0];
        r[9] = |p[63:32];
        for (int k = 0; k < 11; k++) r[10+k] = p[MIR[k]];
      end
      8'h04: r = p[31:0];
      8'h08: r = p[63:32];
      8'h0C: r = {24'h0, m_fen, m_sel};
      8'h10: r = m_en[31:0];
      8'h14: r = m_en[63:32];
      8'h18: r = {24'h0, m_enl};
      8'h1C: r = ~m_en[31:0];
      8'h20: r = ~m_en[63:32];
      8'h24: r = ~{24'h0, m_enl};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h00: return "R6/R7";
      8'h04, 8'h08: return "R5";
      8'h0C: return "R8";
      8'h10, 8'h14, 8'h18: return "R2/R3";
      8'h1C, 8'h20, 8'h24: return "R4";
      default: return "R13";
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h0C: begin m_sel = d[6:0]; m_fen = d[7]; end
      8'h10: m_en[31:0]  = m_en[31:0] | d;
      8'h14: m_en[63:32] = m_en[63:32] | d;
      8'h18: m_enl       = m_enl | d[7:0];
      8'h1C: m_en[31:0]  = m_en[31:0] & ~d;
      8'h20: m_en[63:32] = m_en[63:32] & ~d;
      8'h24: m_enl       = m_enl & ~d[7:0];
      default: ;
    endcase
  endtask

  function automatic logic model_fiq();
    if (!m_fen) return 1'b0;
    if (m_sel < 7'd64) return per[m_sel[5:0]];
    if (m_sel < 7'd72) return loc[m_sel[2:0]];
    return 1'b0;
  endfunction

  function automatic string fiq_tag();
    if (!m_fen) return "R11";
    if (m_sel < 7'd64) return "R9";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_outputs();
    check("R12", {31'h0, irq}, {31'h0, (|(per & m_en)) | (|(loc & m_enl))});
    check(fiq_tag(), {31'h0, fiq}, {31'h0, model_fiq()});
  endtask

  // One request; outputs sampled two edges later (R14).
  task automatic do_op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [63:0] p, input logic [7:0] l);
    logic [31:0] exp;
    @(negedge clk);
    per = p; loc = l;
    valid = 1'b1; write = wr; addr = a; wdata = d;
    exp = model_read(a);
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    if (!wr) begin
      check("R14", {31'h0, rsp}, 32'h1);
      check(read_tag(a), rdata, exp);
    end else begin
      check("R14", {31'h0, rsp}, 32'h0);
      model_write(a, d);
    end
    @(negedge clk);
    check_outputs();
  endtask

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [63:0] p;
    logic [7:0]  l;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h10, 32'h0000_0681, 64'h0, 8'h00},
    '{1'b0, 8'h00, 32'h0, 64'h0000_0000_0000_0680, 8'h00},
    '{1'b0, 8'h04, 32'h0, 64'h0000_0000_0000_0680, 8'h00},
    '{1'b1, 8'h14, 32'h4060_0000, 64'h0, 8'h00},
    '{1'b0, 8'h00, 32'h0, 64'h4060_0000_0000_0080, 8'h00},
    '{1'b0, 8'h08, 32'h0, 64'h4060_0000_0000_0080, 8'h00},
    '{1'b1, 8'h18, 32'h0000_00A5, 64'h0, 8'hFF},
    '{1'b0, 8'h00, 32'h0, 64'h0, 8'h3C},
    '{1'b0, 8'h24, 32'h0, 64'h0, 8'h00},
    '{1'b1, 8'h1C, 32'h0000_0080, 64'h0000_0000_0000_0080, 8'h00},
    '{1'b0, 8'h10, 32'h0, 64'h0, 8'h00},
    '{1'b0, 8'h1C, 32'h0, 64'h0, 8'h00},
    '{1'b1, 8'h0C, 32'h0000_0085, 64'h0000_0000_0000_0020, 8'h00},
    '{1'b1, 8'h0C, 32'h0000_00C2, 64'h0, 8'h04},
    '{1'b1, 8'h0C, 32'h0000_00CA, 64'h0, 8'hFF},
    '{1'b0, 8'h0C, 32'h0, 64'h0, 8'h00},
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 64'h0, 8'h00},
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 64'h0, 8'h00},
    '{1'b1, 8'h30, 32'hFFFF_FFFF, 64'h0, 8'h00},
    '{1'b0, 8'h30, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF},
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 64'hFFFF_0000_0000_0000, 8'h00},
    '{1'b0, 8'h14, 32'h0, 64'h0, 8'h00},
    '{1'b1, 8'h24, 32'h0000_00FF, 64'h0, 8'h00},
    '{1'b1, 8'h0C, 32'h0000_0005, 64'h0000_0000_0000_0020, 8'h00}
  };

  initial begin
    #(5.0 * 150000);
    n_fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    m_en = '0; m_enl = '0; m_sel = '0; m_fen = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check("R1", {29'h0, irq, fiq, rsp}, 32'h0);
    rst_n = 1'b1;
    do_op(1'b0, 8'h10, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    do_op(1'b0, 8'h0C, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);

    for (int i = 0; i < NV; i++)
      do_op(TBL[i].wr, TBL[i].a, TBL[i].d, TBL[i].p, TBL[i].l);

    // Random level toggles with partial masks
    do_op(1'b1, 8'h10, 32'hF0F0_1234, 64'h0, 8'h00);
    do_op(1'b1, 8'h14, 32'h0F0F_8000, 64'h0, 8'h00);
    do_op(1'b1, 8'h18, 32'h0000_0033, 64'h0, 8'h00);
    for (int i = 0; i < 200; i++) begin
      if (i % 10 == 0)
        do_op(1'b1, 8'h0C, {24'h0, 1'b1, 7'(i / 2)}, per, loc);
      do_op(1'b0, 8'((i % 10) * 4), 32'h0, {$urandom, $urandom}, 8'($urandom));
    end

    // R1: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {29'h0, irq, fiq, rsp}, 32'h0);
    rst_n = 1'b1;
    m_en = '0; m_enl = '0; m_sel = '0; m_fen = 1'b0;
    do_op(1'b0, 8'h10, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    do_op(1'b0, 8'h14, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    do_op(1'b0, 8'h18, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    do_op(1'b0, 8'h0C, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule